// File: doc/BRIEF.md
# RTC Alarm Comparator with Repeat Masks

This block is the alarm half of a real-time clock. It keeps four alarm bytes in BCD: seconds, minutes, hours and day of month. Bit 7 of each byte is a repeat-mask bit that removes that field from the comparison. A time-of-day counter elsewhere supplies the live BCD fields and a strobe once per second. On each strobe the block compares the live time against the unmasked alarm fields. When they agree and the alarm is enabled, it raises a one-cycle interrupt pulse.

The write port checks every alarm byte before storing it and quietly drops values outside the legal range of the field. A separate enable bit, written through its own strobe, gates the interrupt. Any stored alarm byte can be read back at any time through a combinational read select.

The sequencer has three states. SEQ_WAIT idles until a strobe arrives (transition WAIT->EVAL on a strobe). SEQ_EVAL holds the match result captured at the strobe. It moves EVAL->PULSE when that result is a hit and the enable is set, and EVAL->WAIT otherwise. SEQ_PULSE drives the interrupt for one cycle, then takes PULSE->EVAL if another strobe is present or PULSE->WAIT if not.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset all four alarm bytes read 0x00, the enable reads 0 and the interrupt is low.
- R2: Register select 0 is seconds and 1 is minutes. A write to either is stored as the full byte only when its bits [6:4]*10 + bits [3:0] is at most 59. The stored byte, including bit 7, reads back unchanged.
- R3: Register select 2 is hours. A write is stored only when bits [5:4]*10 + bits [3:0] is at most 23.
- R4: Register select 3 is date. A write is stored only when bit [4]*10 + bits [3:0] is nonzero, so bit 5 plays no part in the check.
- R5: A write that fails its range check leaves the addressed byte exactly as it was.
- R6: With all four masks clear, a strobe is a hit only when date[5:0], hour[5:0], minute[6:0] and second[6:0] all equal the live fields.
- R7: With only the date mask set, the match compares hour, minute and second.
- R8: With the date and hour masks set and the others clear, the match compares minute and second.
- R9: With date, hour and minute masks set and the second mask clear, the match compares only second.
- R10: Every other mask combination, including all four set, makes every strobe a hit.
- R11: A strobe sampled at clock edge N is matched against the alarm bytes held before edge N, so a write in the same cycle is not seen. The interrupt is high for exactly the one cycle after edge N+1.
- R12: The enable value held before edge N+1 gates the pulse. A strobe sampled at edge N+1, while the result is still being evaluated, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Once-per-second strobe from the time counter |
| now_sec | input | 8 | Live seconds, BCD |
| now_min | input | 8 | Live minutes, BCD |
| now_hour | input | 8 | Live hours, BCD |
| now_date | input | 8 | Live day of month, BCD |
| wr_en | input | 1 | Alarm byte write strobe |
| wr_sel | input | 2 | Alarm byte select (0 sec, 1 min, 2 hour, 3 date) |
| wr_data | input | 8 | Alarm byte write value |
| en_wr | input | 1 | Enable bit write strobe |
| en_data | input | 1 | Enable bit write value |
| rd_sel | input | 2 | Alarm byte read select |
| rd_data | output | 8 | Selected alarm byte |
| alarm_en | output | 1 | Current enable bit |
| irq | output | 1 | One-cycle alarm interrupt pulse |

## Verification
Two functions can land in the same cycle: a strobe being captured, and a register write to an alarm byte or the enable. The bench drives an alarm-byte write in the same cycle as a matching strobe and expects the pulse, which shows the old byte was compared. It writes the enable together with a strobe and expects the new enable to gate the pulse. It clears the enable in the cycle after a strobe and expects the pulse to still appear. A behavioural model updated on every edge judges the interrupt, the enable and the read-back in every cycle, alongside named directed checks.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 4;
    localparam int SEL_W      = $clog2(NUM_FIELDS);
    localparam int MASK_BIT   = FIELD_W - 1;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DATE = 2'd3
    } field_e;

    typedef enum logic [2:0] {
        RPT_MONTH,
        RPT_DAY,
        RPT_HOUR,
        RPT_MINUTE,
        RPT_SECOND
    } repeat_e;

    typedef enum logic [1:0] {
        SEQ_WAIT,
        SEQ_EVAL,
        SEQ_PULSE
    } seq_e;

    // Bits of each field that take part in the time comparison
    function automatic logic [FIELD_W-1:0] cmp_mask(input int idx);
        return (idx < 2) ? 8'h7F : 8'h3F;
    endfunction

    // Binary value of a two-digit BCD byte limited to the given tens bits
    function automatic logic [6:0] bcd_val(input logic [2:0] tens, input logic [3:0] ones);
        return 7'(tens) * 7'd10 + 7'(ones);
    endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [SEL_W-1:0]                     wr_sel,
    input  logic [FIELD_W-1:0]                   wr_data,
    input  logic                                 en_wr,
    input  logic                                 en_data,
    output logic [NUM_FIELDS-1:0][FIELD_W-1:0]   alarm_q,
    output logic                                 en_q
);
    logic [6:0] dec_val;
    logic       wr_ok;

    // Range check of the incoming byte for the addressed field
    always_comb begin
        dec_val = '0;
        wr_ok   = 1'b0;
        unique case (field_e'(wr_sel))
            FLD_SEC, FLD_MIN: begin
                dec_val = bcd_val(wr_data[6:4], wr_data[3:0]);
                wr_ok   = (dec_val <= 7'd59);
            end
            FLD_HOUR: begin
                dec_val = bcd_val({1'b0, wr_data[5:4]}, wr_data[3:0]);
                wr_ok   = (dec_val <= 7'd23);
            end
            FLD_DATE: begin
                dec_val = bcd_val({2'b00, wr_data[4]}, wr_data[3:0]);
                wr_ok   = (dec_val != 7'd0);
            end
            default: begin
                dec_val = '0;
                wr_ok   = 1'b0;
            end
        endcase
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (!rst_n)
                alarm_q[g] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(g)) && wr_ok)
                alarm_q[g] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (en_wr)
            en_q <= en_data;
    end

    // R5: a seconds byte with tens digit of 6 or more never lands
    a_r5_sec_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == FLD_SEC && wr_data[6:4] >= 3'd6) |=> $stable(alarm_q[FLD_SEC]));

    // R4: a date byte whose low five bits are zero is dropped
    a_r4_date_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == FLD_DATE && wr_data[4:0] == 5'd0) |=> $stable(alarm_q[FLD_DATE]));

    // R3: hours with tens digit 3 never land
    a_r3_hour_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == FLD_HOUR && wr_data[5:4] == 2'd3) |=> $stable(alarm_q[FLD_HOUR]));

    // R2: without a write strobe every byte holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(alarm_q));
endmodule

// File: rtl/alarm_mode_decode.sv
module alarm_mode_decode
    import rtc_alarm_pkg::*;
(
    input  logic [NUM_FIELDS-1:0] masks,   // index by field_e
    output repeat_e               mode
);
    always_comb begin
        unique case ({masks[FLD_DATE], masks[FLD_HOUR], masks[FLD_MIN], masks[FLD_SEC]})
            4'b0000: mode = RPT_MONTH;
            4'b1000: mode = RPT_DAY;
            4'b1100: mode = RPT_HOUR;
            4'b1110: mode = RPT_MINUTE;
            default: mode = RPT_SECOND;
        endcase
    end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_q,
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] live,
    input  repeat_e                            mode,
    output logic                               hit
);
    logic [NUM_FIELDS-1:0] eq;
    logic [NUM_FIELDS-1:0] care;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_eq
        assign eq[g] = (((alarm_q[g] ^ live[g]) & cmp_mask(g)) == '0);
    end

    // care bits ordered {date, hour, min, sec}
    always_comb begin
        unique case (mode)
            RPT_MONTH:  care = 4'b1111;
            RPT_DAY:    care = 4'b0111;
            RPT_HOUR:   care = 4'b0011;
            RPT_MINUTE: care = 4'b0001;
            RPT_SECOND: care = 4'b0000;
            default:    care = 4'b0000;
        endcase
    end

    assign hit = &(eq | ~care);
endmodule

// File: rtl/alarm_seq.sv
module alarm_seq
    import rtc_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic en,
    output logic irq
);
    seq_e state, state_nx;
    logic hit_q;
    logic take;

    // a strobe is taken unless a result is still being evaluated
    assign take = tick && (state != SEQ_EVAL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_WAIT;
            hit_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (take)
                hit_q <= hit;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_WAIT:  state_nx = tick ? SEQ_EVAL : SEQ_WAIT;
            SEQ_EVAL:  state_nx = (hit_q && en) ? SEQ_PULSE : SEQ_WAIT;
            SEQ_PULSE: state_nx = tick ? SEQ_EVAL : SEQ_WAIT;
            default:   state_nx = SEQ_WAIT;
        endcase
    end

    always_comb begin
        irq = 1'b0;
        unique case (state)
            SEQ_PULSE: irq = 1'b1;
            default:   irq = 1'b0;
        endcase
    end

    // R11: the pulse lasts a single cycle
    a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R11: a pulse follows a strobe by two edges
    a_r11_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick, 2));

    // R12: the pulse needs the enable held at the evaluation edge
    a_r12_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en));

    // R12: evaluation is only ever entered from a strobe
    a_r12_eval_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_EVAL) |-> $past(tick));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [7:0]   now_sec,
    input  logic [7:0]   now_min,
    input  logic [7:0]   now_hour,
    input  logic [7:0]   now_date,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [7:0]   wr_data,
    input  logic         en_wr,
    input  logic         en_data,
    input  logic [1:0]   rd_sel,
    output logic [7:0]   rd_data,
    output logic         alarm_en,
    output logic         irq
);
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_q;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] live;
    logic [NUM_FIELDS-1:0]              masks;
    repeat_e                            mode;
    logic                               hit;
    logic                               en_q;

    assign live[FLD_SEC]  = now_sec;
    assign live[FLD_MIN]  = now_min;
    assign live[FLD_HOUR] = now_hour;
    assign live[FLD_DATE] = now_date;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_mask
        assign masks[g] = alarm_q[g][MASK_BIT];
    end

    alarm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .en_wr   (en_wr),
        .en_data (en_data),
        .alarm_q (alarm_q),
        .en_q    (en_q)
    );

    alarm_mode_decode u_mode (
        .masks (masks),
        .mode  (mode)
    );

    alarm_match u_match (
        .alarm_q (alarm_q),
        .live    (live),
        .mode    (mode),
        .hit     (hit)
    );

    alarm_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .hit   (hit),
        .en    (en_q),
        .irq   (irq)
    );

    assign rd_data  = alarm_q[rd_sel];
    assign alarm_en = en_q;

    // R1: first cycle out of reset shows a cleared block
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> (alarm_q == '0 && !en_q && !irq));
endmodule

// File: tb/tb_rtc_alarm_match.sv
module tb_rtc_alarm_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hour = 8'h00, now_date = 8'h00;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       en_wr = 1'b0, en_data = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       alarm_en, irq;

    int total = 0;
    int bad = 0;
    bit live_cmp = 1'b0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [7:0] m_reg [4];
    logic       m_en, m_busy, m_match, m_irq;

    always #5 clk = ~clk;

    rtc_alarm_match dut (.*);

    function automatic bit ref_ok(input int sel, input int d);
        int v;
        case (sel)
            0, 1: begin v = ((d >> 4) & 7) * 10 + (d & 15); return v <= 59; end
            2:    begin v = ((d >> 4) & 3) * 10 + (d & 15); return v <= 23; end
            default: begin v = ((d >> 4) & 1) * 10 + (d & 15); return v != 0; end
        endcase
    endfunction

    function automatic bit ref_hit(input int s, input int m, input int h, input int d);
        bit ms, mm, mh, md, es, em, eh, ed;
        ms = m_reg[0][7]; mm = m_reg[1][7]; mh = m_reg[2][7]; md = m_reg[3][7];
        es = (m_reg[0] & 8'h7F) == (s & 8'h7F);
        em = (m_reg[1] & 8'h7F) == (m & 8'h7F);
        eh = (m_reg[2] & 8'h3F) == (h & 8'h3F);
        ed = (m_reg[3] & 8'h3F) == (d & 8'h3F);
        if (!md && !mh && !mm && !ms) return ed && eh && em && es;
        if ( md && !mh && !mm && !ms) return eh && em && es;
        if ( md &&  mh && !mm && !ms) return em && es;
        if ( md &&  mh &&  mm && !ms) return es;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_reg[i] <= 8'h00;
            m_en <= 0; m_busy <= 0; m_match <= 0; m_irq <= 0;
        end else begin
            m_irq  <= m_busy && m_match && m_en;
            m_busy <= tick && !m_busy;
            if (tick && !m_busy) m_match <= ref_hit(now_sec, now_min, now_hour, now_date);
            if (wr_en && ref_ok(wr_sel, wr_data)) m_reg[wr_sel] <= wr_data;
            if (en_wr) m_en <= en_data;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // R11 model comparison on every cycle, away from the rising edge
    always @(negedge clk) begin
        if (live_cmp) begin
            chk("R11 model irq", {7'd0, irq}, {7'd0, m_irq});
            chk("R12 model enable", {7'd0, alarm_en}, {7'd0, m_en});
            chk("R2 model readback", rd_data, m_reg[rd_sel]);
        end
    end

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] sel, input logic [7:0] exp);
        rd_sel = sel;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic set_en(input logic v);
        en_wr = 1'b1; en_data = v;
        step;
        en_wr = 1'b0;
    endtask

    task automatic set_now(input logic [7:0] s, m, h, d);
        now_sec = s; now_min = m; now_hour = h; now_date = d;
    endtask

    task automatic tick_chk(input string tag, input logic [7:0] s, m, h, d, input logic exp);
        set_now(s, m, h, d);
        tick = 1'b1;
        step;
        tick = 1'b0;
        chk("R11 no pulse in evaluation cycle", {7'd0, irq}, 8'd0);
        step;
        chk(tag, {7'd0, irq}, {7'd0, exp});
        step;
        chk("R11 pulse is one cycle", {7'd0, irq}, 8'd0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) step;
        rst_n = 1'b1;
        step;
        live_cmp = 1'b1;
        // R1 reset state
        rd_chk("R1 sec reset", 2'd0, 8'h00);
        rd_chk("R1 min reset", 2'd1, 8'h00);
        rd_chk("R1 hour reset", 2'd2, 8'h00);
        rd_chk("R1 date reset", 2'd3, 8'h00);
        chk("R1 enable reset", {7'd0, alarm_en}, 8'd0);
        chk("R1 irq reset", {7'd0, irq}, 8'd0);

        // R2 seconds and minutes range
        wr(2'd0, 8'h59); rd_chk("R2 sec 59 accepted", 2'd0, 8'h59);
        wr(2'd0, 8'hD9); rd_chk("R2 sec mask bit kept", 2'd0, 8'hD9);
        wr(2'd0, 8'h60); rd_chk("R5 sec 60 dropped", 2'd0, 8'hD9);
        wr(2'd1, 8'h5A); rd_chk("R5 min 5A dropped", 2'd1, 8'h00);
        wr(2'd1, 8'h45); rd_chk("R2 min 45 accepted", 2'd1, 8'h45);
        // R3 hours range
        wr(2'd2, 8'h23); rd_chk("R3 hour 23 accepted", 2'd2, 8'h23);
        wr(2'd2, 8'h24); rd_chk("R3 hour 24 dropped", 2'd2, 8'h23);
        wr(2'd2, 8'h92); rd_chk("R3 hour masked 12 accepted", 2'd2, 8'h92);
        // R4 date range
        wr(2'd3, 8'h00); rd_chk("R4 date 00 dropped", 2'd3, 8'h00);
        wr(2'd3, 8'h20); rd_chk("R4 date 20 dropped, bit5 ignored", 2'd3, 8'h00);
        wr(2'd3, 8'h15); rd_chk("R4 date 15 accepted", 2'd3, 8'h15);

        // plain monthly alarm
        wr(2'd0, 8'h30); wr(2'd2, 8'h12);
        set_en(1'b1);
        tick_chk("R6 monthly match", 8'h30, 8'h45, 8'h12, 8'h15, 1'b1);
        tick_chk("R6 monthly date differs", 8'h30, 8'h45, 8'h12, 8'h16, 1'b0);
        // daily
        wr(2'd3, 8'h95);
        tick_chk("R7 daily match", 8'h30, 8'h45, 8'h12, 8'h03, 1'b1);
        tick_chk("R7 daily minute differs", 8'h30, 8'h44, 8'h12, 8'h03, 1'b0);
        // hourly
        wr(2'd2, 8'h92);
        tick_chk("R8 hourly match", 8'h30, 8'h45, 8'h07, 8'h03, 1'b1);
        tick_chk("R8 hourly second differs", 8'h31, 8'h45, 8'h07, 8'h03, 1'b0);
        // per minute
        wr(2'd1, 8'hC5);
        tick_chk("R9 minute match", 8'h30, 8'h11, 8'h07, 8'h03, 1'b1);
        tick_chk("R9 minute second differs", 8'h31, 8'h11, 8'h07, 8'h03, 1'b0);
        // every second: all masks, then odd combinations
        wr(2'd0, 8'hB0);
        tick_chk("R10 all masks", 8'h59, 8'h59, 8'h23, 8'h31, 1'b1);
        wr(2'd3, 8'h15);
        tick_chk("R10 masks 0111", 8'h01, 8'h02, 8'h03, 8'h04, 1'b1);
        wr(2'd1, 8'h45); wr(2'd2, 8'h12);
        tick_chk("R10 masks 0001", 8'h01, 8'h02, 8'h03, 8'h04, 1'b1);

        // R12 enable off
        set_en(1'b0);
        tick_chk("R12 disabled no pulse", 8'h01, 8'h02, 8'h03, 8'h04, 1'b0);
        // R12 enable written in the strobe cycle is seen
        en_wr = 1'b1; en_data = 1'b1; tick = 1'b1;
        step;
        en_wr = 1'b0; tick = 1'b0;
        step;
        chk("R12 enable with strobe gates on", {7'd0, irq}, 8'd1);
        step;
        // R12 enable cleared at the evaluation edge is too late
        tick = 1'b1;
        step;
        tick = 1'b0; en_wr = 1'b1; en_data = 1'b0;
        step;
        en_wr = 1'b0;
        chk("R12 late disable still pulses", {7'd0, irq}, 8'd1);
        step;
        set_en(1'b1);
        // R12 strobe during evaluation ignored
        tick = 1'b1;
        step;
        step;
        tick = 1'b0;
        chk("R12 first of back-to-back pulses", {7'd0, irq}, 8'd1);
        step;
        chk("R12 second strobe ignored", {7'd0, irq}, 8'd0);
        step;
        chk("R12 still quiet", {7'd0, irq}, 8'd0);

        // R11 write with strobe: old bytes compared
        wr(2'd0, 8'h30);
        set_now(8'h30, 8'h45, 8'h12, 8'h15);
        tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h31;
        step;
        tick = 1'b0; wr_en = 1'b0;
        step;
        chk("R11 write with strobe uses old byte", {7'd0, irq}, 8'd1);
        step;
        tick_chk("R11 new byte applies next strobe", 8'h30, 8'h45, 8'h12, 8'h15, 1'b0);
        tick_chk("R6 new second matches", 8'h31, 8'h45, 8'h12, 8'h15, 1'b1);

        repeat (2) step;
        finish_run();
    end
endmodule